// File: doc/BRIEF.md
# Processor-Side Bus Cycle Controller with Burst and Bus Surrender

This block is the bus-cycle state machine of a processor-side master on a synchronous bus. The bus uses an address strobe and a ready handshake. The core presents one request at a time: an address, a write flag, write data and a cacheable flag. It holds the request steady until the controller reports completion. The controller runs the request on the bus as a single read, a single write, or a four-beat line read. A line read is used when the core asks for a cacheable read. The controller adds wait states for as long as the target holds ready inactive.

Each bus cycle opens with an address cycle, in which the address is valid and the strobe is low for exactly one clock. Data cycles follow, and a data cycle ends a transfer only on a clock edge where ready is low. A line read has one address cycle and then four data transfers. Its address steps through the 8-byte beats of the 32-byte line that holds the requested address. Between bus cycles, another master can claim the bus with the hold input. The controller lets any cycle in flight finish, then raises hold-acknowledge and starts nothing new until hold is released.

Read data goes back to the core with a data-valid pulse for each beat. A completion pulse ends each request.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: A bus cycle starts with exactly one address cycle. In that cycle `ads_n` is 0 and `bus_addr` shows the transfer address. In the next cycle `ads_n` is back at 1 and the controller is in its data phase.
- R2: In the data phase, a transfer completes only at a clock edge where `brdy_n` is sampled 0. Edges with `brdy_n` at 1 are wait states, and the address stays on the bus through them. `brdy_n` sampled during the address cycle has no effect.
- R3: `w_r_n` is 1 for a write and 0 for a read, and it stays constant through the address cycle and all data cycles. During a write cycle `bus_data_oe` is 1 and `bus_wdata` carries the core's write data.
- R4: A request with `req_cacheable`=1 and `req_write`=0 runs as a line read. It has one address cycle and four data transfers, with `cache_n` at 0 throughout. The beat addresses are the requested address with bits [4:0] cleared, plus 0, 8, 16 and 24, in that order.
- R5: When no bus cycle is in progress, `bus_addr` is 0, `ads_n` is 1, `cache_n` is 1, `w_r_n` is 0 and `bus_data_oe` is 0.
- R6: When `hold` is sampled 1, the controller finishes any bus cycle in progress and then raises `hlda`. While `hlda` is 1, it issues no address strobe and drives no data.
- R7: `hlda` falls at the first clock edge where `hold` is sampled 0. A request pending from the core then starts with a new address cycle at the following edge.
- R8: The cycle after each read transfer completes, `rsp_valid` is 1 for one cycle and `rsp_rdata` holds the data sampled at that edge. `done` is a one-cycle pulse in the cycle after a single transfer completes, and it comes together with the fourth `rsp_valid` of a line read. A write raises `done` and never `rsp_valid`.
- R9: There is at least one idle cycle between `done` and the next address strobe, even when `req_valid` is still 1. A cacheable write runs as a single write with `cache_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request pending, held until done |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| req_cacheable | input | 1 | Cacheable; turns a read into a line read |
| bus_addr | output | 32 | Bus address, 0 when idle |
| ads_n | output | 1 | Active-low address strobe |
| w_r_n | output | 1 | Direction: 1 write, 0 read |
| cache_n | output | 1 | Active-low line-read indicator |
| bus_wdata | output | 64 | Data driven on writes |
| bus_data_oe | output | 1 | Write data drive enable |
| bus_rdata | input | 64 | Data from the target |
| brdy_n | input | 1 | Active-low transfer ready |
| hold | input | 1 | Another master requests the bus |
| hlda | output | 1 | Bus surrendered |
| rsp_valid | output | 1 | Read beat valid to core |
| rsp_rdata | output | 64 | Read beat data |
| done | output | 1 | Request complete pulse |

## Verification
The hardest case to reach is `hold` arriving in the middle of a bus cycle that is stretched by wait states. The bench raises `hold` in the address cycle of a read and keeps `brdy_n` high for two data cycles. It then checks that `hlda` stays low until ready closes the transfer, and that `hlda` rises only in the same cycle as `done`. A second scenario leaves a core request pending under `hlda`, to show that the request waits and then starts one edge after `hlda` falls. The line read adds a wait state before its second beat, to show that the beat address and counter hold still through it.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_DATA_W     = 64;
    localparam int DEF_LINE_BYTES = 32;
    localparam int DEF_BEAT_BYTES = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_DATA  = 2'd2,
        ST_YIELD = 2'd3
    } bus_state_e;

    typedef struct packed {
        logic write;
        logic burst;
    } xfer_kind_t;

    function automatic xfer_kind_t classify(input logic wr, input logic cacheable);
        xfer_kind_t k;
        k.write = wr;
        k.burst = cacheable & ~wr;
        return k;
    endfunction

endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
    import bus_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       done_q,
    input  logic       hold,
    input  logic       brdy_n,
    input  logic       final_beat,
    output bus_state_e state,
    output logic       start,
    output logic       beat_ok,
    output logic       finish
);

    bus_state_e nxt;

    assign start   = (state == ST_IDLE) && req_valid && !hold && !done_q;
    assign beat_ok = (state == ST_DATA) && !brdy_n;
    assign finish  = beat_ok && final_beat;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (hold)       nxt = ST_YIELD;
                else if (start) nxt = ST_ADDR;
            end
            ST_ADDR:  nxt = ST_DATA;
            ST_DATA: begin
                if (finish)     nxt = hold ? ST_YIELD : ST_IDLE;
            end
            ST_YIELD: begin
                if (!hold)      nxt = ST_IDLE;
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/bus_seq_datapath.sv
module bus_seq_datapath
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int LINE_BYTES = DEF_LINE_BYTES,
    parameter int BEAT_BYTES = DEF_BEAT_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              beat_ok,
    input  logic              finish,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_cacheable,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] cur_addr,
    output xfer_kind_t        kind,
    output logic              final_beat,
    output logic [DATA_W-1:0] wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              done
);

    localparam int LINE_LSB = $clog2(LINE_BYTES);
    localparam int BEAT_LSB = $clog2(BEAT_BYTES);
    localparam int IDX_W    = LINE_LSB - BEAT_LSB;
    localparam int BEATS    = LINE_BYTES / BEAT_BYTES;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  beat_q;
    xfer_kind_t        kind_q;

    assign kind       = kind_q;
    assign final_beat = !kind_q.burst || (beat_q == LAST_IDX);

    always_comb begin
        if (kind_q.burst)
            cur_addr = {addr_q[ADDR_W-1:LINE_LSB], beat_q, {BEAT_LSB{1'b0}}};
        else
            cur_addr = addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            beat_q    <= '0;
            kind_q    <= '0;
            wdata     <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            done      <= 1'b0;
        end else begin
            rsp_valid <= beat_ok && !kind_q.write;
            done      <= finish;
            if (beat_ok && !kind_q.write)
                rsp_rdata <= bus_rdata;
            if (start) begin
                addr_q <= req_addr;
                wdata  <= req_wdata;
                kind_q <= classify(req_write, req_cacheable);
                beat_q <= '0;
            end else if (beat_ok && !final_beat) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int LINE_BYTES = DEF_LINE_BYTES,
    parameter int BEAT_BYTES = DEF_BEAT_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_cacheable,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              ads_n,
    output logic              w_r_n,
    output logic              cache_n,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              brdy_n,
    input  logic              hold,
    output logic              hlda,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              done
);

    bus_state_e        state;
    logic              start, beat_ok, finish, final_beat, on_bus;
    logic [ADDR_W-1:0] cur_addr;
    xfer_kind_t        kind;

    bus_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .done_q     (done),
        .hold       (hold),
        .brdy_n     (brdy_n),
        .final_beat (final_beat),
        .state      (state),
        .start      (start),
        .beat_ok    (beat_ok),
        .finish     (finish)
    );

    bus_seq_datapath #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LINE_BYTES (LINE_BYTES),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_dp (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .beat_ok       (beat_ok),
        .finish        (finish),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .req_wdata     (req_wdata),
        .req_cacheable (req_cacheable),
        .bus_rdata     (bus_rdata),
        .cur_addr      (cur_addr),
        .kind          (kind),
        .final_beat    (final_beat),
        .wdata         (bus_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .done          (done)
    );

    assign on_bus      = (state == ST_ADDR) || (state == ST_DATA);
    assign bus_addr    = on_bus ? cur_addr : '0;
    assign ads_n       = (state != ST_ADDR);
    assign w_r_n       = on_bus && kind.write;
    assign cache_n     = !(on_bus && kind.burst);
    assign bus_data_oe = on_bus && kind.write;
    assign hlda        = (state == ST_YIELD);

endmodule

// File: rtl/bus_cycle_ctrl_chk.sv
module bus_cycle_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ads_n,
    input logic w_r_n,
    input logic cache_n,
    input logic bus_data_oe,
    input logic brdy_n,
    input logic hold,
    input logic hlda,
    input logic rsp_valid,
    input logic done
);

    assert_strobe_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        !ads_n |=> ads_n);

    assert_done_needs_ready_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(!brdy_n));

    assert_dir_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !ads_n |=> $stable(w_r_n));

    assert_line_is_read_R4: assert property (@(posedge clk) disable iff (rst)
        !cache_n |-> !w_r_n);

    assert_quiet_under_hlda_R6: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (ads_n && cache_n && !bus_data_oe));

    assert_hlda_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(hlda) |-> $past(hold));

    assert_hlda_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(hlda) |-> $past(!hold));

    assert_beat_needs_ready_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!brdy_n));

    assert_gap_after_done_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> ads_n);

endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ads_n       (ads_n),
    .w_r_n       (w_r_n),
    .cache_n     (cache_n),
    .bus_data_oe (bus_data_oe),
    .brdy_n      (brdy_n),
    .hold        (hold),
    .hlda        (hlda),
    .rsp_valid   (rsp_valid),
    .done        (done)
);

// File: tb/bus_cycle_ctrl_test.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        req_cacheable = 1'b0;
    logic [31:0] bus_addr;
    logic        ads_n, w_r_n, cache_n, bus_data_oe, hlda, rsp_valid, done;
    logic [63:0] bus_wdata, rsp_rdata;
    logic [63:0] bus_rdata = '0;
    logic        brdy_n = 1'b1;
    logic        hold = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bus_cycle_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_cacheable(req_cacheable),
        .bus_addr(bus_addr), .ads_n(ads_n), .w_r_n(w_r_n), .cache_n(cache_n),
        .bus_wdata(bus_wdata), .bus_data_oe(bus_data_oe), .bus_rdata(bus_rdata),
        .brdy_n(brdy_n), .hold(hold), .hlda(hlda), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .done(done)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        check({tag, " R5 addr"}, bus_addr, 0);
        check({tag, " R5 ads_n"}, ads_n, 1);
        check({tag, " R5 cache_n"}, cache_n, 1);
        check({tag, " R5 w_r_n"}, w_r_n, 0);
        check({tag, " R5 oe"}, bus_data_oe, 0);
    endtask

    task automatic run_single(input bit wr, input logic [31:0] a, input logic [63:0] wd,
                              input bit cach, input int waits, input logic [63:0] rd);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = wr; req_wdata = wd; req_cacheable = cach;
        brdy_n = 1;
        @(negedge clk);
        check("R1 strobe low in address cycle", ads_n, 0);
        check("R1 address valid", bus_addr, a);
        check("R3 direction", w_r_n, wr);
        check("R9 single has cache_n high", cache_n, 1);
        check("R3 oe", bus_data_oe, wr);
        if (wr) check("R3 write data", bus_wdata, wd);
        brdy_n = 0; bus_rdata = rd;
        @(negedge clk);
        check("R2 ready in address cycle ignored", done, 0);
        check("R1 strobe high in data cycle", ads_n, 1);
        check("R3 direction held", w_r_n, wr);
        if (waits > 0) begin
            brdy_n = 1;
            for (int i = 0; i < waits; i++) begin
                @(negedge clk);
                check("R2 wait keeps address", bus_addr, a);
                check("R2 no done during wait", done, 0);
                check("R3 direction during wait", w_r_n, wr);
            end
            brdy_n = 0;
        end
        @(negedge clk);
        check("R8 done pulse", done, 1);
        check("R8 rsp_valid only for read", rsp_valid, !wr);
        if (!wr) check("R8 read data", rsp_rdata, rd);
        check_idle("after single");
        brdy_n = 1;
        @(negedge clk);
        check("R9 no strobe right after done", ads_n, 1);
        check("R8 done is one cycle", done, 0);
        req_valid = 0;
    endtask

    task automatic run_line_read(input logic [31:0] a);
        logic [31:0] base;
        base = a & 32'hFFFF_FFE0;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = 0; req_cacheable = 1; brdy_n = 1;
        @(negedge clk);
        check("R4 one strobe", ads_n, 0);
        check("R4 cache_n low", cache_n, 0);
        check("R4 aligned base", bus_addr, base);
        check("R4 read direction", w_r_n, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R8 beat valid", rsp_valid, 1);
                check("R8 beat data", rsp_rdata, 64'hA5A5_0000_0000_0000 | 64'(i - 1));
                check("R8 no done mid-line", done, 0);
            end
            check("R4 no second strobe", ads_n, 1);
            check("R4 beat address", bus_addr, base + 32'(8 * i));
            check("R4 cache_n held", cache_n, 0);
            if (i == 1) begin
                brdy_n = 1;
                @(negedge clk);
                check("R2 wait holds beat", bus_addr, base + 32'd8);
                check("R8 no valid on wait", rsp_valid, 0);
            end
            brdy_n = 0;
            bus_rdata = 64'hA5A5_0000_0000_0000 | 64'(i);
        end
        @(negedge clk);
        check("R8 fourth valid", rsp_valid, 1);
        check("R8 fourth data", rsp_rdata, 64'hA5A5_0000_0000_0003);
        check("R8 done with fourth beat", done, 1);
        check_idle("after line");
        brdy_n = 1; req_valid = 0; req_cacheable = 0;
        @(negedge clk);
        check("R8 done one cycle", done, 0);
    endtask

    task automatic hold_when_idle();
        @(negedge clk);
        hold = 1;
        @(negedge clk);
        check("R6 hlda rises in idle", hlda, 1);
        req_valid = 1; req_addr = 32'h0000_4440; req_write = 0; req_cacheable = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R6 no strobe under hlda", ads_n, 1);
            check("R6 hlda stays", hlda, 1);
        end
        hold = 0;
        @(negedge clk);
        check("R7 hlda drops", hlda, 0);
        check("R7 not yet started", ads_n, 1);
        @(negedge clk);
        check("R7 pending request starts", ads_n, 0);
        check("R7 pending address", bus_addr, 32'h0000_4440);
        brdy_n = 0; bus_rdata = 64'h77;
        @(negedge clk);
        @(negedge clk);
        check("R7 resumed read done", done, 1);
        check("R7 resumed read data", rsp_rdata, 64'h77);
        req_valid = 0; brdy_n = 1;
        @(negedge clk);
    endtask

    task automatic hold_mid_cycle();
        @(negedge clk);
        req_valid = 1; req_addr = 32'h0000_0100; req_write = 0; req_cacheable = 0; brdy_n = 1;
        @(negedge clk);
        check("R6 cycle started", ads_n, 0);
        hold = 1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check("R6 no hlda while cycle runs", hlda, 0);
            check("R6 address kept", bus_addr, 32'h0000_0100);
        end
        brdy_n = 0; bus_rdata = 64'hBEEF;
        @(negedge clk);
        check("R6 cycle finished", done, 1);
        check("R6 hlda after finish", hlda, 1);
        check_idle("under hlda");
        req_valid = 0; brdy_n = 1;
        @(negedge clk);
        check("R6 hlda held", hlda, 1);
        hold = 0;
        @(negedge clk);
        check("R7 hlda released", hlda, 0);
        check("R7 no request, stays idle", ads_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("reset hlda", hlda, 0);
        check("reset done", done, 0);
        check("reset rsp_valid", rsp_valid, 0);
        check_idle("reset");

        run_single(0, 32'h0000_1004, '0, 0, 0, 64'h0123_4567_89AB_CDEF);
        run_single(1, 32'h0000_2008, 64'hDEAD_BEEF_0000_1111, 0, 2, '0);
        run_single(1, 32'h0000_3010, 64'h5555_AAAA_5555_AAAA, 1, 1, '0);
        run_single(0, 32'h0000_3018, '0, 0, 3, 64'hFEDC_BA98_7654_3210);
        run_line_read(32'h0000_1234);
        run_line_read(32'h8000_0047);
        hold_when_idle();
        hold_mid_cycle();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule